// File: doc/BRIEF.md
# RAID-6 Dual Parity Generator

This block forms the two redundancy words of a RAID-6 stripe. For each stripe offset it takes one wide beat per data disk and returns two words. The first word, P, is the bytewise XOR of every data disk. The second word, Q, is a Reed-Solomon syndrome over GF(2^8) with generator 2 and reduction polynomial 0x11d.

Beats arrive on a valid/ready stream, starting with the highest-numbered data disk and ending with disk 0. The beat for disk 0 carries a last marker. Q is built by Horner's rule. The first beat of an offset loads both running values. Each later beat doubles Q in GF(2^8) and folds the new data into both words. Every byte lane of the beat has its own independent datapath, so a 32-byte beat updates 32 bytes in a single cycle.

The finished P and Q are shown together on an output stream. They stay there until the consumer takes them. While a result is waiting, no further input is accepted. In a stripe of N total slots, the last two slots hold P and Q, so the block sees N-2 data beats per offset.

Top module: `pq_syndrome_gen`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and out_p and out_q are all zero.
- R2: A stripe made of a single beat (in_last set on the first beat) yields out_p equal to out_q equal to that beat's data.
- R3: out_p equals the bytewise XOR of every beat accepted for the stripe.
- R4: For beats accepted in the order D(n-1) first down to D(0) last, out_q per byte equals the sum over i of g^i times D(i) in GF(2^8), with g = 2 and reduction polynomial 0x11d.
- R5: Doubling a byte shifts it left by one bit and drops the carry. If bit 7 of the original byte was 1, the result is then XORed with 0x1d; for example 0x80 becomes 0x1d and 0xff becomes 0xe3.
- R6: Byte lane k of out_p and out_q (bits 8k+7 down to 8k) depends only on byte lane k of the input beats.
- R7: out_valid rises in the cycle after the beat with in_last is accepted. While out_ready is low, out_valid, out_p and out_q stay unchanged.
- R8: in_ready is 0 whenever out_valid is 1. Data offered on in_data during that time is not folded into any result.
- R9: In the cycle after a result is taken (out_valid and out_ready both 1), out_valid is 0 and out_p and out_q read zero. The next stripe is unaffected by the one before it.
- R10: Cycles in which no beat is accepted and no result is taken leave out_p and out_q unchanged, even between the beats of one stripe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A data beat is offered |
| in_ready | output | 1 | The block can accept a beat |
| in_last | input | 1 | This beat is disk 0, the final beat of the stripe |
| in_data | input | 8*LANES | One disk's bytes for the current offset |
| out_valid | output | 1 | P and Q are ready |
| out_ready | input | 1 | Consumer takes P and Q |
| out_p | output | 8*LANES | XOR parity |
| out_q | output | 8*LANES | GF(2^8) syndrome |

## Verification
The bench runs a four-lane configuration and sweeps all 256 byte values through a two-disk stripe with a zero second disk. That isolates the doubling step, so a wrong reduction constant, a wrong MSB test or a carry that leaks shows up on a single Q byte. Stripes of one to seven disks with idle gaps between beats catch a design that doubles too often, doubles the first beat, or updates on idle cycles. A single-lane pattern catches a design that carries bits between lanes. The bench holds back out_ready while offering junk beats; a design that drops the result, lets it change, or folds the junk into the next stripe produces a wrong or shifted value. Taking a result and then checking for zeros catches accumulators that are never cleared.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GF_POLY_LOW = 8'h1d;
endpackage

// File: rtl/pq_gf_dbl.sv
module pq_gf_dbl #(
  parameter logic [7:0] POLY = pq_pkg::GF_POLY_LOW
) (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [7:0] neg_mask;
  always_comb begin
    neg_mask = ($signed(din) < 0) ? 8'hff : 8'h00;
    dout = {din[6:0], 1'b0} ^ (neg_mask & POLY);
  end
endmodule

// File: rtl/pq_lane_acc.sv
module pq_lane_acc #(
  parameter logic [7:0] POLY = pq_pkg::GF_POLY_LOW
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_first,
  input  logic       fold,
  input  logic       clear,
  input  logic [7:0] d,
  output logic [7:0] p,
  output logic [7:0] q
);
  logic [7:0] q_dbl;

  pq_gf_dbl #(.POLY(POLY)) u_dbl (.din(q), .dout(q_dbl));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      p <= '0;
      q <= '0;
    end else if (load_first) begin
      p <= d;
      q <= d;
    end else if (fold) begin
      p <= p ^ d;
      q <= q_dbl ^ d;
    end
  end
endmodule

// File: rtl/pq_flow_ctrl.sv
module pq_flow_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_first,
  output logic fold,
  output logic clear
);
  logic expect_first;
  logic accept;

  always_comb begin
    in_ready   = !out_valid;
    accept     = in_valid && in_ready;
    load_first = accept && expect_first;
    fold       = accept && !expect_first;
    clear      = out_valid && out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      expect_first <= 1'b1;
    end else begin
      if (accept) expect_first <= in_last;
      if (accept && in_last) out_valid <= 1'b1;
      else if (clear)        out_valid <= 1'b0;
    end
  end

  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R8
  AST_LAST_RAISES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> out_valid); // R7
endmodule

// File: rtl/pq_syndrome_gen.sv
module pq_syndrome_gen #(
  parameter int LANES = 32,
  parameter logic [7:0] POLY = pq_pkg::GF_POLY_LOW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_last,
  input  logic [8*LANES-1:0]  in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [8*LANES-1:0]  out_p,
  output logic [8*LANES-1:0]  out_q
);
  localparam int BW = pq_pkg::BYTE_W;
  localparam int DW = BW * LANES;

  logic load_first, fold, clear;

  pq_flow_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .load_first(load_first), .fold(fold), .clear(clear)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pq_lane_acc #(.POLY(POLY)) u_acc (
      .clk(clk), .rst(rst), .load_first(load_first), .fold(fold),
      .clear(clear), .d(in_data[k*BW +: BW]),
      .p(out_p[k*BW +: BW]), .q(out_q[k*BW +: BW])
    );
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q))); // R7
  AST_CLEAR_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && out_p == {DW{1'b0}} && out_q == {DW{1'b0}})); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !(out_valid && out_ready)) |=> ($stable(out_p) && $stable(out_q))); // R10
endmodule

// File: tb/pq_syndrome_gen_bench.sv
module pq_syndrome_gen_bench;
  localparam int LANES = 4;
  localparam int DW = 8 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_p, out_q;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] stim [0:7];

  always #5 clk = ~clk;

  pq_syndrome_gen #(.LANES(LANES)) u_pq_syndrome_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
  );

  function automatic logic [7:0] gdbl(input logic [7:0] b);
    int v;
    v = int'(b) * 2;
    if (v >= 256) v = v ^ 'h11d;
    return v[7:0];
  endfunction

  function automatic logic [DW-1:0] vdbl(input logic [DW-1:0] x);
    logic [DW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*8 +: 8] = gdbl(x[k*8 +: 8]);
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] d, input logic last, input int gap);
    in_valid = 1'b1; in_data = d; in_last = last;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
  endtask

  // expected P and Q for disks stim[n-1] .. stim[0], in that order
  task automatic run_stripe(input int n, input int gap, input string req);
    logic [DW-1:0] ep, eq;
    ep = '0; eq = '0;
    for (int i = n - 1; i >= 0; i--) begin
      ep = ep ^ stim[i];
      eq = vdbl(eq) ^ stim[i];
    end
    for (int i = n - 1; i >= 0; i--) send(stim[i], i == 0, (i == 0) ? 0 : gap);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " P"}, out_p, ep);
    check({req, " Q"}, out_q, eq);
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    check("R9 cleared", out_p | out_q, '0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 P/Q zero", out_p | out_q, '0);

    // R2 single-disk
    stim[0] = 32'hdeadbeef;
    run_stripe(1, 0, "R2");

    // R5 exhaustive doubling: disk1=values, disk0=0 -> Q = dbl(values)
    for (int b = 0; b < 256; b += LANES) begin
      for (int k = 0; k < LANES; k++) stim[1][k*8 +: 8] = 8'(b + k);
      stim[0] = '0;
      run_stripe(2, 0, "R5");
    end
    stim[1] = 32'hff80_7f01; stim[0] = '0;
    run_stripe(2, 0, "R5 corners 0xff->0xe3 0x80->0x1d");

    // R3/R4/R10 multi-disk stripes with gaps
    for (int n = 1; n <= 7; n++) begin
      for (int i = 0; i < n; i++) stim[i] = 32'h9e37_79b9 * (i + 3) ^ (n * 32'h0101_0101);
      run_stripe(n, n % 3, "R3 R4 R10");
    end

    // R6 single active lane
    for (int k = 0; k < LANES; k++) begin
      for (int i = 0; i < 5; i++) stim[i] = '0;
      stim[4][k*8 +: 8] = 8'hc3; stim[2][k*8 +: 8] = 8'h81;
      run_stripe(5, 0, "R6");
    end

    // R7/R8 backpressure with junk offered
    stim[2] = 32'h1122_3344; stim[1] = 32'h8899_aabb; stim[0] = 32'hf0e1_d2c3;
    send(stim[2], 1'b0, 0);
    send(stim[1], 1'b0, 0);
    send(stim[0], 1'b1, 0);
    held = out_q;
    in_valid = 1'b1; in_data = 32'h5555_5555; in_last = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R7 held valid", {31'd0, out_valid}, 32'd1);
      check("R7 Q stable", out_q, held);
    end
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    check("R7 P", out_p, stim[2] ^ stim[1] ^ stim[0]);
    out_ready = 1'b1; @(posedge clk); #1; out_ready = 1'b0;
    check("R9 valid low", {31'd0, out_valid}, 32'd0);
    stim[0] = 32'h0bad_cafe;
    run_stripe(1, 0, "R8 junk not folded");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule